// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit linear address into a physical address by visiting two levels of in-memory tables built from 4 KB pages. A directory-base register names the one page directory in use. For each accepted request the walker reads one directory entry. If that entry is present, it reads one table entry and then forms the physical address from the table entry's frame number and the untouched 12-bit page offset. An entry whose present flag is clear ends the walk with a fault. The fault output reports which level failed and which linear address was being translated.

Memory is reached through a simple port. The walker raises a one-cycle read strobe with an address. It then waits, for any number of cycles, until the memory answers with a valid strobe and 32 bits of data. When paging is turned off, the walker hands the linear address back unchanged and performs no reads. The walker takes one request at a time. The request side sees it ready only while it is idle.

The controller has seven named states:
- IDLE: waits for a request.
- RD_DIR: issues the directory read.
- WT_DIR: waits for the directory data.
- RD_TBL: issues the table read.
- WT_TBL: waits for the table data.
- DONE: one cycle with the result valid.
- FAULT: one cycle with the fault valid.

Its transitions are:
- IDLE→RD_DIR when a request arrives with paging on.
- IDLE→DONE when a request arrives with paging off.
- RD_DIR→WT_DIR unconditionally.
- WT_DIR→RD_TBL on a present directory entry.
- WT_DIR→FAULT on an absent directory entry.
- RD_TBL→WT_TBL unconditionally.
- WT_TBL→DONE on a present table entry.
- WT_TBL→FAULT on an absent table entry.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `xlate_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1 and `mem_rd`, `done` and `fault` are 0.
- R2: A request accepted with `paging_en` = 0 produces `done` in the very next cycle, with `phys_addr` equal to the linear address and no memory read.
- R3: The directory read address is {base[31:12], 12'h000} + linear[31:22]×4. Bits 11..0 of the value written through `base_we`/`base_d` are ignored, and a new write applies to walks started after it.
- R4: The table read is issued only after a present directory entry has arrived. Its address is {dir_entry[31:12], 12'h000} + linear[21:12]×4.
- R5: On a present table entry, `phys_addr` = {tbl_entry[31:12], linear[11:0]} is qualified by a `done` pulse that lasts exactly one cycle, after which `req_ready` is 1 again.
- R6: A directory entry with bit 0 (present) = 0 raises `fault` for one cycle with `fault_level` = 0 and `fault_addr` = linear address, and no table read follows.
- R7: A table entry with bit 0 (present) = 0 raises `fault` for one cycle with `fault_level` = 1 and `fault_addr` = linear address, even when its upper bits are non-zero.
- R8: A request is taken only while `req_ready` is 1. `req_valid` and `req_lin` held during a walk change neither the walk nor its result.
- R9: Each read is a one-cycle `mem_rd` pulse. The walker waits any number of cycles for `mem_rvalid`.
- R10: `paging_en` is sampled only when a request is accepted. Changing it during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| paging_en | input | 1 | 1 = translate through the tables, 0 = pass the address through |
| base_we | input | 1 | Write strobe for the directory-base register |
| base_d | input | 32 | New directory base (bits 11..0 ignored) |
| req_valid | input | 1 | Translation request |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse, `phys_addr` valid |
| phys_addr | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle pulse, translation failed |
| fault_level | output | 1 | 0 = directory entry absent, 1 = table entry absent |
| fault_addr | output | 32 | Linear address of the failed walk |

## Verification
Walks are run with paging off, with a full mapping at low and at all-ones indices, with an absent directory entry, and with an absent table entry that has non-zero frame bits. Together these separate the bypass path, both index fields and both fault levels. The same mapping is walked with zero and with several cycles of memory latency, which shows that the wait states hold. A second run of that mapping keeps a conflicting request and a flipped paging enable on the inputs throughout, which exposes any mid-walk capture. A rewrite of the base with junk in its low bits checks that only the frame part roots the next walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WT_DIR,
        ST_RD_TBL,
        ST_WT_TBL,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic {
        LVL_DIR = 1'b0,
        LVL_TBL = 1'b1
    } fault_lvl_t;
endpackage

// File: rtl/xw_entry_addr.sv
module xw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFFS_W-1:0] frame_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [ADDR_W-1:0]        addr_o
);
    localparam int ENTRY_SHIFT = 2;  // 4-byte entries

    always_comb begin
        addr_o = {frame_i, {OFFS_W{1'b0}}} + (ADDR_W'(idx_i) << ENTRY_SHIFT);
    end
endmodule

// File: rtl/xw_fsm.sv
module xw_fsm
    import xw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       paging_en,
    input  logic       mem_rvalid,
    input  logic       entry_present,
    output logic       req_ready,
    output logic       mem_rd,
    output logic       sel_tbl,
    output logic       cap_req,
    output logic       cap_dir,
    output logic       cap_tbl,
    output logic       done,
    output logic       fault,
    output fault_lvl_t fault_lvl
);
    walk_state_t st, st_nx;
    fault_lvl_t  lvl_q, lvl_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            lvl_q <= LVL_DIR;
        end else begin
            st    <= st_nx;
            lvl_q <= lvl_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        lvl_nx = lvl_q;
        unique case (st)
            ST_IDLE:   if (req_valid) st_nx = paging_en ? ST_RD_DIR : ST_DONE;
            ST_RD_DIR: st_nx = ST_WT_DIR;
            ST_WT_DIR: if (mem_rvalid) begin
                if (entry_present) st_nx = ST_RD_TBL;
                else begin
                    st_nx  = ST_FAULT;
                    lvl_nx = LVL_DIR;
                end
            end
            ST_RD_TBL: st_nx = ST_WT_TBL;
            ST_WT_TBL: if (mem_rvalid) begin
                if (entry_present) st_nx = ST_DONE;
                else begin
                    st_nx  = ST_FAULT;
                    lvl_nx = LVL_TBL;
                end
            end
            ST_DONE:   st_nx = ST_IDLE;
            ST_FAULT:  st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (st == ST_IDLE);
        mem_rd    = (st == ST_RD_DIR) || (st == ST_RD_TBL);
        sel_tbl   = (st == ST_RD_TBL);
        cap_req   = (st == ST_IDLE) && req_valid;
        cap_dir   = (st == ST_WT_DIR) && mem_rvalid && entry_present;
        cap_tbl   = (st == ST_WT_TBL) && mem_rvalid && entry_present;
        done      = (st == ST_DONE);
        fault     = (st == ST_FAULT);
        fault_lvl = lvl_q;
    end

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=> (done && !mem_rd));
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    assert_dir_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WT_DIR && mem_rvalid && !entry_present) |=> (fault && fault_lvl == LVL_DIR && !mem_rd));
    assert_tbl_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WT_TBL && mem_rvalid && !entry_present) |=> (fault && fault_lvl == LVL_TBL));
    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_d,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin,
    output logic              req_ready,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              fault,
    output logic              fault_level,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int FRAME_W = ADDR_W - OFFS_W;
    localparam int DIR_LSB = OFFS_W + IDX_W;

    logic [FRAME_W-1:0] base_frame_q, tbl_frame_q, pg_frame_q;
    logic [ADDR_W-1:0]  lin_q, dir_ea, tbl_ea;
    logic               sel_tbl, cap_req, cap_dir, cap_tbl;
    fault_lvl_t         lvl;
    logic               unused_bits;

    assign unused_bits = ^{base_d[OFFS_W-1:0], mem_rdata[OFFS_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_frame_q <= '0;
            lin_q        <= '0;
            tbl_frame_q  <= '0;
            pg_frame_q   <= '0;
        end else begin
            if (base_we) base_frame_q <= base_d[ADDR_W-1:OFFS_W];
            if (cap_req) begin
                lin_q      <= req_lin;
                pg_frame_q <= req_lin[ADDR_W-1:OFFS_W];
            end
            if (cap_dir) tbl_frame_q <= mem_rdata[ADDR_W-1:OFFS_W];
            if (cap_tbl) pg_frame_q  <= mem_rdata[ADDR_W-1:OFFS_W];
        end
    end

    xw_entry_addr #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_dir_ea (
        .frame_i (base_frame_q),
        .idx_i   (lin_q[DIR_LSB+IDX_W-1:DIR_LSB]),
        .addr_o  (dir_ea)
    );

    xw_entry_addr #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_tbl_ea (
        .frame_i (tbl_frame_q),
        .idx_i   (lin_q[DIR_LSB-1:OFFS_W]),
        .addr_o  (tbl_ea)
    );

    xw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .paging_en     (paging_en),
        .mem_rvalid    (mem_rvalid),
        .entry_present (mem_rdata[0]),
        .req_ready     (req_ready),
        .mem_rd        (mem_rd),
        .sel_tbl       (sel_tbl),
        .cap_req       (cap_req),
        .cap_dir       (cap_dir),
        .cap_tbl       (cap_tbl),
        .done          (done),
        .fault         (fault),
        .fault_lvl     (lvl)
    );

    assign mem_addr    = sel_tbl ? tbl_ea : dir_ea;
    assign phys_addr   = {pg_frame_q, lin_q[OFFS_W-1:0]};
    assign fault_addr  = lin_q;
    assign fault_level = lvl;

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(lin_q));
    assert_sampled_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !req_ready) |=> (!done && !req_ready));
endmodule

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0, rst_n = 0;
    logic        paging_en = 0, base_we = 0, req_valid = 0, mem_rvalid = 0;
    logic [31:0] base_d = 0, req_lin = 0, mem_rdata = 0;
    logic        req_ready, mem_rd, done, fault, fault_level;
    logic [31:0] mem_addr, phys_addr, fault_addr;

    int n_chk = 0, n_fail = 0;
    logic [31:0] base_m = 0;
    logic [31:0] mem_m [bit [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_walker u_xlate_walker (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .base_we(base_we), .base_d(base_d),
        .req_valid(req_valid), .req_lin(req_lin), .req_ready(req_ready),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .phys_addr(phys_addr), .fault(fault), .fault_level(fault_level),
        .fault_addr(fault_addr)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : 32'h0;
    endfunction

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_we = 1; base_d = v;
        @(negedge clk); base_we = 0;
        base_m = v;
    endtask

    task automatic walk(input logic [31:0] lin, input bit pg, input int lat,
                        input bit hold, input string req);
        logic [31:0] exp_q[$];
        string       tag_q[$];
        logic [31:0] ent, a, exp_phys;
        bit          exp_fault, exp_lvl, first_done;
        int          guard;
        exp_fault = 0; exp_lvl = 0; exp_phys = lin;
        if (pg) begin
            a = {base_m[31:12], 12'h0} + {20'h0, lin[31:22], 2'b00};
            exp_q.push_back(a); tag_q.push_back("R3");
            ent = rd_mem(a);
            if (!ent[0]) begin exp_fault = 1; exp_lvl = 0; end
            else begin
                a = {ent[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00};
                exp_q.push_back(a); tag_q.push_back("R4");
                ent = rd_mem(a);
                if (!ent[0]) begin exp_fault = 1; exp_lvl = 1; end
                else exp_phys = {ent[31:12], lin[11:0]};
            end
        end
        @(negedge clk); req_valid = 1; req_lin = lin; paging_en = pg;
        @(negedge clk);
        if (hold) begin req_lin = 32'h0080_0000; paging_en = !pg; end
        else req_valid = 0;
        first_done = done;
        guard = 0;
        while (!(done || fault) && guard < 200) begin
            chk(req_ready == 0, "R8", "ready while busy", {31'h0, req_ready}, 32'h0);
            if (mem_rd) begin
                a = mem_addr;
                if (exp_q.size() > 0) begin
                    chk(a == exp_q[0], tag_q[0], "read address", a, exp_q[0]);
                    void'(exp_q.pop_front()); void'(tag_q.pop_front());
                end else chk(0, req, "unexpected read", a, 32'h0);
                @(negedge clk);
                chk(mem_rd == 0, "R9", "read strobe width", {31'h0, mem_rd}, 32'h0);
                repeat (lat) @(negedge clk);
                mem_rvalid = 1; mem_rdata = rd_mem(a);
                @(negedge clk);
                mem_rvalid = 0; mem_rdata = 0;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        req_valid = 0;
        if (!pg) chk(first_done == 1, "R2", "bypass latency", {31'h0, first_done}, 32'h1);
        chk(exp_q.size() == 0, req, "reads missing", exp_q.size(), 32'h0);
        if (exp_fault) begin
            chk(fault == 1 && done == 0, req, "fault pulse", {30'h0, fault, done}, 32'h2);
            chk(fault_level == exp_lvl, req, "fault level", {31'h0, fault_level}, {31'h0, exp_lvl});
            chk(fault_addr == lin, req, "fault address", fault_addr, lin);
        end else begin
            chk(done == 1 && fault == 0, req, "done pulse", {30'h0, done, fault}, 32'h2);
            chk(phys_addr == exp_phys, req, "physical address", phys_addr, exp_phys);
        end
        @(negedge clk);
        chk(done == 0 && fault == 0 && req_ready == 1, "R5", "return to idle",
            {29'h0, done, fault, req_ready}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", "run timed out", 32'h0, 32'h1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && mem_rd == 0 && done == 0 && fault == 0, "R1", "reset state",
            {28'h0, req_ready, mem_rd, done, fault}, 32'h8);

        mem_m[32'h0001_2004] = 32'h0005_0003;
        mem_m[32'h0005_000C] = 32'h0ABC_D001;
        mem_m[32'h0001_2FFC] = 32'h0006_0001;
        mem_m[32'h0006_0FFC] = 32'hFFFF_F001;
        mem_m[32'h0005_0010] = 32'h1234_5000;
        mem_m[32'h0003_4004] = 32'h0007_0001;
        mem_m[32'h0007_000C] = 32'h0088_8001;
        set_base(32'h0001_2ABC);

        walk(32'hDEAD_BEEF, 0, 0, 0, "R2");
        walk(32'h0040_3123, 1, 0, 0, "R5");   // expects 0ABCD123
        walk(32'h0040_3123, 1, 5, 0, "R9");   // slow memory
        walk(32'hFFFF_FFFF, 1, 2, 0, "R5");   // top indices
        walk(32'h0080_0000, 1, 1, 0, "R6");   // absent directory entry
        walk(32'h0040_4000, 1, 3, 0, "R7");   // absent table entry, frame bits set
        walk(32'h0040_3123, 1, 2, 1, "R10");  // held request, flipped enable (R8)
        set_base(32'h0003_4FFF);
        walk(32'h0040_3123, 1, 1, 0, "R3");   // expects 00888123
        summary();
    end
endmodule